// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a relative conditional branch instruction is taken, and from that decision computes the address the program counter moves to next. It is purely combinational. The opcode, the processor status flags (carry, zero, negative, overflow, half-carry and interrupt mask), the level of the external interrupt request pin, a signed 8-bit displacement and the sequential program counter go in. The sequential program counter is the address just after the displacement byte. The taken decision, the next program counter, the cycle cost of the branch and an illegal-opcode indication come out.

Two opcode pages are decoded. On the 0x2x page, opcode bits [3:1] select one of eight flag tests. On the 0x9x page, only 0x90 to 0x93 are recognised, and they form the signed compares built from N, V and Z. On both pages, opcode bit 0 inverts the selected test. Fetch of the displacement byte happens outside this unit. The instruction sequencer uses the reported cycle cost to pace itself.

Top module: `branch_decide`

## Requirements
- R1: For opcodes 0x20 to 0x2F with bit 0 clear, opcode bits [3:1] select the taken condition: 0 always; 1 C and Z both clear; 2 C clear; 3 Z clear; 4 H clear; 5 N clear; 6 I clear; 7 interrupt pin input high.
- R2: On the 0x2x page, opcode bit 0 set inverts the condition that bits [3:1] select. 0x21 is therefore never taken, and 0x2F is taken when the pin input is low.
- R3: Opcode 0x90 is taken when N equals V. Opcode 0x91 is taken when N differs from V.
- R4: Opcode 0x92 is taken when Z is clear and N equals V. Opcode 0x93 is taken in every other flag state.
- R5: Opcodes 0x94 to 0x9F, and every opcode whose upper nibble is neither 0x2 nor 0x9, raise `illegal_o`. An illegal opcode is never taken, leaves the next PC equal to `pc_seq_i`, and reports a cost of 0.
- R6: A taken branch sets the next PC to `pc_seq_i` plus the sign-extended displacement, wrapping modulo 2^PC_W.
- R7: A branch that is not taken sets the next PC to `pc_seq_i`.
- R8: Every legal opcode reports a cost of 2 cycles, taken or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Branch opcode |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_h_i | input | 1 | Half-carry flag |
| flag_i_i | input | 1 | Interrupt mask flag |
| irq_pin_i | input | 1 | Level of the external interrupt request pin |
| disp_i | input | DISP_W | Signed branch displacement |
| pc_seq_i | input | PC_W | Address following the displacement byte |
| take_o | output | 1 | Branch is taken |
| pc_next_o | output | PC_W | Next program counter |
| cost_o | output | 2 | Cycle cost of the branch (2 when legal, 0 when illegal) |
| illegal_o | output | 1 | Opcode is not a branch this unit decodes |

## Verification
The bench builds the unit with its defaults: a 16-bit program counter and an 8-bit displacement. At these sizes the full opcode space can be swept against all 128 combinations of the six flags and the pin. Every table entry, every inversion and every illegal code is therefore visited under every flag state. A second sweep takes all 256 displacements across program counters placed near zero, near the sign boundary and near the top of the address space, which reaches both forward and backward wrap of the target adder.

// File: rtl/branch_decide_pkg.sv
package branch_decide_pkg;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic h;
        logic i;
    } flags_t;

    localparam logic [3:0] PAGE_REL  = 4'h2;
    localparam logic [3:0] PAGE_SCMP = 4'h9;
    localparam logic [1:0] BRANCH_COST = 2'd2;

    typedef enum logic [2:0] {
        SEL_ALWAYS = 3'd0,
        SEL_HIGHER = 3'd1,
        SEL_NOCARRY = 3'd2,
        SEL_NONZERO = 3'd3,
        SEL_NOHALF = 3'd4,
        SEL_PLUS = 3'd5,
        SEL_UNMASKED = 3'd6,
        SEL_PINHIGH = 3'd7
    } rel_sel_e;

endpackage

// File: rtl/branch_rel_cond.sv
module branch_rel_cond
    import branch_decide_pkg::*;
(
    input  logic [2:0] sel_i,
    input  flags_t     flags_i,
    input  logic       pin_i,
    output logic       base_o
);
    always_comb begin
        case (rel_sel_e'(sel_i))
            SEL_ALWAYS:   base_o = 1'b1;
            SEL_HIGHER:   base_o = ~(flags_i.c | flags_i.z);
            SEL_NOCARRY:  base_o = ~flags_i.c;
            SEL_NONZERO:  base_o = ~flags_i.z;
            SEL_NOHALF:   base_o = ~flags_i.h;
            SEL_PLUS:     base_o = ~flags_i.n;
            SEL_UNMASKED: base_o = ~flags_i.i;
            default:      base_o = pin_i;
        endcase
    end
endmodule

// File: rtl/branch_scmp_cond.sv
module branch_scmp_cond
    import branch_decide_pkg::*;
(
    input  logic [2:0] sel_i,
    input  flags_t     flags_i,
    output logic       base_o,
    output logic       valid_o
);
    logic ge;
    always_comb begin
        ge = ~(flags_i.n ^ flags_i.v);
        base_o  = 1'b0;
        valid_o = 1'b0;
        case (sel_i)
            3'd0: begin base_o = ge;               valid_o = 1'b1; end
            3'd1: begin base_o = ge & ~flags_i.z;  valid_o = 1'b1; end
            default: begin base_o = 1'b0;          valid_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc_seq_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              take_i,
    output logic [PC_W-1:0]   pc_next_o
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext = disp_i[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        pc_next_o = take_i ? (pc_seq_i + disp_ext) : pc_seq_i;
    end
endmodule

// File: rtl/branch_decide.sv
module branch_decide
    import branch_decide_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [7:0]        opcode_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              flag_h_i,
    input  logic              flag_i_i,
    input  logic              irq_pin_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [PC_W-1:0]   pc_seq_i,
    output logic              take_o,
    output logic [PC_W-1:0]   pc_next_o,
    output logic [1:0]        cost_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic       take;
        logic       illegal;
        logic [1:0] cost;
    } decision_t;

    flags_t    flags_d;
    logic      rel_base_d;
    logic      scmp_base_d;
    logic      scmp_valid_d;
    decision_t res_d;

    assign flags_d = '{c: flag_c_i, z: flag_z_i, n: flag_n_i,
                       v: flag_v_i, h: flag_h_i, i: flag_i_i};

    branch_rel_cond u_rel (
        .sel_i   (opcode_i[3:1]),
        .flags_i (flags_d),
        .pin_i   (irq_pin_i),
        .base_o  (rel_base_d)
    );

    branch_scmp_cond u_scmp (
        .sel_i   (opcode_i[3:1]),
        .flags_i (flags_d),
        .base_o  (scmp_base_d),
        .valid_o (scmp_valid_d)
    );

    always_comb begin
        res_d = '{take: 1'b0, illegal: 1'b1, cost: 2'd0};
        if (opcode_i[7:4] == PAGE_REL) begin
            res_d.take    = rel_base_d ^ opcode_i[0];
            res_d.illegal = 1'b0;
            res_d.cost    = BRANCH_COST;
        end else if (opcode_i[7:4] == PAGE_SCMP && scmp_valid_d) begin
            res_d.take    = scmp_base_d ^ opcode_i[0];
            res_d.illegal = 1'b0;
            res_d.cost    = BRANCH_COST;
        end
    end

    branch_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc_seq_i  (pc_seq_i),
        .disp_i    (disp_i),
        .take_i    (res_d.take),
        .pc_next_o (pc_next_o)
    );

    assign take_o    = res_d.take;
    assign illegal_o = res_d.illegal;
    assign cost_o    = res_d.cost;

    always_comb begin
        if (!$isunknown({opcode_i, flags_d, irq_pin_i, disp_i, pc_seq_i})) begin
            AST_ILLEGAL_NOT_TAKEN: assert (!(illegal_o && take_o)) else $error("illegal opcode taken"); // R5
            AST_FALLTHROUGH_PC: assert (take_o || pc_next_o == pc_seq_i) else $error("fall-through pc moved"); // R7
            AST_ALWAYS_TAKEN: assert (opcode_i != 8'h20 || take_o) else $error("always-branch not taken"); // R1
            AST_NEVER_TAKEN: assert (opcode_i != 8'h21 || !take_o) else $error("never-branch taken"); // R2
            AST_LEGAL_COST: assert (illegal_o || cost_o == BRANCH_COST) else $error("bad cost"); // R8
        end
    end
endmodule

// File: tb/branch_decide_tb_top.sv
module branch_decide_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [7:0]  opcode;
    logic        fc, fz, fn, fv, fh, fi, pin;
    logic [7:0]  disp;
    logic [15:0] pc_seq;
    logic        take;
    logic [15:0] pc_next;
    logic [1:0]  cost;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    branch_decide dut_i (
        .opcode_i(opcode), .flag_c_i(fc), .flag_z_i(fz), .flag_n_i(fn),
        .flag_v_i(fv), .flag_h_i(fh), .flag_i_i(fi), .irq_pin_i(pin),
        .disp_i(disp), .pc_seq_i(pc_seq),
        .take_o(take), .pc_next_o(pc_next), .cost_o(cost), .illegal_o(illegal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%02h flags=%b%b%b%b%b%b pin=%b act=%0h exp=%0h",
                     req, opcode, fc, fz, fn, fv, fh, fi, pin, act, exp);
        end
    endtask

    task automatic apply_and_check();
        logic       exp_take, exp_ill, base;
        logic [1:0] exp_cost;
        logic [15:0] exp_pc;
        string tag;
        exp_ill = 1'b0;
        base = 1'b0;
        tag = "R5";
        if (opcode[7:4] == 4'h2) begin
            tag = opcode[0] ? "R2" : "R1";
            case (opcode[3:1])
                3'd0: base = 1'b1;
                3'd1: base = !fc && !fz;
                3'd2: base = !fc;
                3'd3: base = !fz;
                3'd4: base = !fh;
                3'd5: base = !fn;
                3'd6: base = !fi;
                default: base = pin;
            endcase
        end else if (opcode[7:4] == 4'h9 && opcode[3:1] == 3'd0) begin
            tag = "R3";
            base = (fn == fv);
        end else if (opcode[7:4] == 4'h9 && opcode[3:1] == 3'd1) begin
            tag = "R4";
            base = !fz && (fn == fv);
        end else begin
            exp_ill = 1'b1;
        end
        exp_take = exp_ill ? 1'b0 : (base ^ opcode[0]);
        exp_cost = exp_ill ? 2'd0 : 2'd2;
        exp_pc = exp_take ? (pc_seq + {{8{disp[7]}}, disp}) : pc_seq;
        #5;
        check({tag, " take"}, {31'd0, take}, {31'd0, exp_take});
        check("R5 illegal", {31'd0, illegal}, {31'd0, exp_ill});
        check(exp_ill ? "R5 cost" : "R8 cost", {30'd0, cost}, {30'd0, exp_cost});
        check(exp_take ? "R6 pc" : (exp_ill ? "R5 pc" : "R7 pc"), {16'd0, pc_next}, {16'd0, exp_pc});
    endtask

    initial begin
        int pcs[4] = '{16'h0000, 16'h007F, 16'h8000, 16'hFFF0};
        opcode = 8'h20; {fc, fz, fn, fv, fh, fi, pin} = '0;
        disp = 8'h00; pc_seq = 16'h1234;
        @(negedge clk);
        // Reset-like idle state: always-branch with zero displacement
        apply_and_check();
        // Exhaustive opcode x flag sweep
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 128; f++) begin
                @(negedge clk);
                opcode = op[7:0];
                {fc, fz, fn, fv, fh, fi, pin} = f[6:0];
                disp = 8'(op * 7 + f * 3);
                pc_seq = 16'(op * 257 + f * 509);
                apply_and_check();
            end
        end
        // Displacement sweep with wrap, taken (0x20) and not taken (0x21)
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 256; d++) begin
                for (int o = 0; o < 2; o++) begin
                    @(negedge clk);
                    opcode = o[0] ? 8'h21 : 8'h20;
                    {fc, fz, fn, fv, fh, fi, pin} = '0;
                    disp = d[7:0];
                    pc_seq = pcs[p][15:0];
                    apply_and_check();
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete act=%0d exp=%0d", cycles, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule